// File: doc/BRIEF.md
# AXI Decode-Error Default Slave

This block is the endpoint an interconnect selects when an incoming address hits no mapped target. It presents a complete AXI slave port on all five channels. It takes in any read or write burst and carries that burst through to the end. Write data is drained up to the beat flagged last. A read produces the full number of beats it asked for. The block then answers with the decode-error response code. Because it always finishes the address, data and response handshakes, a stray access to an unmapped region cannot stall the master that issued it.

Next to the bus port sits a small debug log, read directly from output pins. It holds the address, ID and direction of the first offending access, together with a sticky flag that shows the record is occupied. A saturating counter tallies every decode error seen. A one-cycle clear input empties the record and zeroes the counter. The block admits at most one write and one read at a time. A new address on a channel is refused until the response of the transaction already in flight on that channel has been handed over.

Top module: `decerr_sink`

## Requirements
- R1: Every accepted write address is answered by exactly one write response. The response carries resp code 2'b11 (decode error) and an ID equal to the accepted write address ID. Response code values are OKAY=2'b00, EXOKAY=2'b01, SLVERR=2'b10, DECERR=2'b11.
- R2: After a write address is accepted, w_ready is high. Every write data beat is accepted, up to and including the beat with w_last=1. b_valid stays low until that last beat has been accepted, and w_ready drops after it.
- R3: A read with length field L returns exactly L+1 beats. Each beat has r_data=0, r_resp=2'b11 and r_id equal to the accepted read address ID. r_last=1 is set only on beat L+1, and r_valid falls after that beat's handshake.
- R4: aw_ready is low from the write address handshake until the write response handshake completes. ar_ready is low from the read address handshake until the last read beat's handshake completes. Both are high when idle.
- R5: While b_ready or r_ready is held low, the pending b_valid or r_valid stays high with its ID and r_last unchanged.
- R6: The first decode error after reset or clear sets log_valid. It stores the address, the ID and the direction (log_is_write=1 for a write, 0 for a read). These values hold until a clear, whatever errors come later.
- R7: When a write address and a read address are accepted in the same cycle while the log is empty, the write is recorded.
- R8: log_count rises by one for each accepted write or read address, and by two when both are accepted in one cycle. It saturates at 2^CNT_W-1 and never wraps. CNT_W defaults to 16.
- R9: A cycle with log_clear=1 leaves log_valid=0 and log_count=0. Address handshakes in that same cycle are neither recorded nor counted, though the transactions still complete.
- R10: After reset, b_valid, r_valid, w_ready and log_valid are low, log_count is 0, and aw_ready and ar_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write address |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Write burst length minus one (not used; the end of the burst comes from w_last) |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data (discarded) |
| w_strb | input | DATA_W/8 | Write strobes (discarded) |
| w_last | input | 1 | Final write beat |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read address |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read data ID |
| r_data | output | DATA_W | Read data (zero) |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat |
| log_clear | input | 1 | Empties the log and zeroes the counter |
| log_valid | output | 1 | Sticky record-occupied flag |
| log_addr | output | ADDR_W | Address of first recorded error |
| log_id | output | ID_W | ID of first recorded error |
| log_is_write | output | 1 | 1 if the first recorded error was a write |
| log_count | output | CNT_W | Saturating error count |

## Verification
The bench targets bursts of one beat and of many beats, gaps between write beats, and backpressure on both response channels. A design that counts beats wrongly would return one read beat too many or too few, or raise r_last early. A design that answers too soon would raise b_valid before the last write beat. Other targets are simultaneous read and write address acceptance, a clear in the same cycle as a handshake, and counter saturation with a narrow counter. A design that got these wrong would record the read instead of the write, count the cleared-cycle access, or wrap the counter back to a small value.

// File: rtl/decerr_pkg.sv
package decerr_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_DATA = 2'd1,
    WR_RESP = 2'd2
  } wr_state_e;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_BEAT = 1'b1
  } rd_state_e;

endpackage

// File: rtl/decerr_wr_engine.sv
module decerr_wr_engine
  import decerr_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aw_valid,
  input  logic [ID_W-1:0] aw_id,
  output logic            aw_ready,
  input  logic            w_valid,
  input  logic            w_last,
  output logic            w_ready,
  output logic            b_valid,
  input  logic            b_ready,
  output logic [ID_W-1:0] b_id,
  output logic            aw_fire,
  output logic            w_last_fire,
  output logic            b_fire
);

  wr_state_e       state_q, state_d;
  logic [ID_W-1:0] id_q;

  assign aw_ready    = (state_q == WR_IDLE);
  assign w_ready     = (state_q == WR_DATA);
  assign b_valid     = (state_q == WR_RESP);
  assign b_id        = id_q;

  assign aw_fire     = aw_valid & aw_ready;
  assign w_last_fire = w_valid & w_ready & w_last;
  assign b_fire      = b_valid & b_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WR_IDLE: if (aw_fire)     state_d = WR_DATA;
      WR_DATA: if (w_last_fire) state_d = WR_RESP;
      WR_RESP: if (b_fire)      state_d = WR_IDLE;
      default:                  state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (aw_fire) id_q <= aw_id;
    end
  end

endmodule

// File: rtl/decerr_rd_engine.sv
module decerr_rd_engine
  import decerr_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic [ID_W-1:0]  ar_id,
  input  logic [LEN_W-1:0] ar_len,
  output logic             ar_ready,
  output logic             r_valid,
  input  logic             r_ready,
  output logic [ID_W-1:0]  r_id,
  output logic             r_last,
  output logic             ar_fire,
  output logic             r_done
);

  rd_state_e        state_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] beat_q;
  logic             r_fire;

  function automatic logic final_beat(input logic [LEN_W-1:0] beat,
                                      input logic [LEN_W-1:0] len);
    return beat == len;
  endfunction

  function automatic logic [LEN_W-1:0] next_beat(input logic [LEN_W-1:0] beat);
    return beat + LEN_W'(1);
  endfunction

  assign ar_ready = (state_q == RD_IDLE);
  assign r_valid  = (state_q == RD_BEAT);
  assign r_id     = id_q;
  assign r_last   = r_valid & final_beat(beat_q, len_q);

  assign ar_fire  = ar_valid & ar_ready;
  assign r_fire   = r_valid & r_ready;
  assign r_done   = r_fire & r_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      id_q    <= '0;
      len_q   <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        RD_IDLE: begin
          if (ar_fire) begin
            state_q <= RD_BEAT;
            id_q    <= ar_id;
            len_q   <= ar_len;
            beat_q  <= '0;
          end
        end
        RD_BEAT: begin
          if (r_done)      state_q <= RD_IDLE;
          else if (r_fire) beat_q  <= next_beat(beat_q);
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/decerr_log.sv
module decerr_log #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ID_W-1:0]   rd_id,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr,
  output logic [ID_W-1:0]   log_id,
  output logic              log_is_write,
  output logic [CNT_W-1:0]  log_count
);

  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] cur,
                                               input logic [1:0]       inc);
    logic [CNT_W:0] sum;
    sum = {1'b0, cur} + (CNT_W+1)'(inc);
    if (sum > CNT_MAX) sum = CNT_MAX;
    return sum[CNT_W-1:0];
  endfunction

  logic [1:0] evt_num;
  logic       take;

  assign evt_num = {1'b0, wr_evt} + {1'b0, rd_evt};
  assign take    = ~log_valid & (wr_evt | rd_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_valid    <= 1'b0;
      log_addr     <= '0;
      log_id       <= '0;
      log_is_write <= 1'b0;
      log_count    <= '0;
    end else if (clear) begin
      log_valid    <= 1'b0;
      log_addr     <= '0;
      log_id       <= '0;
      log_is_write <= 1'b0;
      log_count    <= '0;
    end else begin
      if (take) begin
        log_valid    <= 1'b1;
        log_is_write <= wr_evt;
        log_addr     <= wr_evt ? wr_addr : rd_addr;
        log_id       <= wr_evt ? wr_id   : rd_id;
      end
      log_count <= sat_add(log_count, evt_num);
    end
  end

endmodule

// File: rtl/decerr_sink.sv
module decerr_sink
  import decerr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last,
  input  logic              log_clear,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr,
  output logic [ID_W-1:0]   log_id,
  output logic              log_is_write,
  output logic [CNT_W-1:0]  log_count
);

  // Named internal events, visible to the bound checker
  logic aw_fire;
  logic w_last_fire;
  logic b_fire;
  logic ar_fire;
  logic r_done;

  // Write data, strobes and the write length are drained without use
  logic unused_wr_side;
  assign unused_wr_side = ^{w_data, w_strb, aw_len};

  assign b_resp = RESP_DECERR;
  assign r_resp = RESP_DECERR;
  assign r_data = '0;

  decerr_wr_engine #(.ID_W(ID_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .aw_valid    (aw_valid),
    .aw_id       (aw_id),
    .aw_ready    (aw_ready),
    .w_valid     (w_valid),
    .w_last      (w_last),
    .w_ready     (w_ready),
    .b_valid     (b_valid),
    .b_ready     (b_ready),
    .b_id        (b_id),
    .aw_fire     (aw_fire),
    .w_last_fire (w_last_fire),
    .b_fire      (b_fire)
  );

  decerr_rd_engine #(.ID_W(ID_W), .LEN_W(LEN_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_valid (ar_valid),
    .ar_id    (ar_id),
    .ar_len   (ar_len),
    .ar_ready (ar_ready),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_id     (r_id),
    .r_last   (r_last),
    .ar_fire  (ar_fire),
    .r_done   (r_done)
  );

  decerr_log #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_log (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (log_clear),
    .wr_evt       (aw_fire),
    .wr_addr      (aw_addr),
    .wr_id        (aw_id),
    .rd_evt       (ar_fire),
    .rd_addr      (ar_addr),
    .rd_id        (ar_id),
    .log_valid    (log_valid),
    .log_addr     (log_addr),
    .log_id       (log_id),
    .log_is_write (log_is_write),
    .log_count    (log_count)
  );

endmodule

// File: rtl/decerr_sink_chk.sv
module decerr_sink_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aw_ready,
  input logic              w_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic              r_last,
  input logic              aw_fire,
  input logic              ar_fire,
  input logic              w_last_fire,
  input logic              r_done,
  input logic              log_clear,
  input logic              log_valid,
  input logic [ADDR_W-1:0] log_addr,
  input logic [ID_W-1:0]   log_id,
  input logic              log_is_write,
  input logic [CNT_W-1:0]  log_count
);

  // R4
  aw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid || w_ready) |-> !aw_ready);

  // R4
  ar_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);

  // R2
  b_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(w_last_fire));

  // R3
  r_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_done |=> !r_valid);

  // R5
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

  // R5
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_last)));

  // R6
  log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clear) |=>
      (log_valid && $stable(log_addr) && $stable(log_id) && $stable(log_is_write)));

  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !log_clear |=> (log_count >= $past(log_count)));

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_clear && !aw_fire && !ar_fire) |=> $stable(log_count));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_clear |=> (!log_valid && log_count == '0));

endmodule

bind decerr_sink decerr_sink_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .aw_ready     (aw_ready),
  .w_ready      (w_ready),
  .b_valid      (b_valid),
  .b_ready      (b_ready),
  .b_id         (b_id),
  .ar_ready     (ar_ready),
  .r_valid      (r_valid),
  .r_ready      (r_ready),
  .r_id         (r_id),
  .r_last       (r_last),
  .aw_fire      (aw_fire),
  .ar_fire      (ar_fire),
  .w_last_fire  (w_last_fire),
  .r_done       (r_done),
  .log_clear    (log_clear),
  .log_valid    (log_valid),
  .log_addr     (log_addr),
  .log_id       (log_id),
  .log_is_write (log_is_write),
  .log_count    (log_count)
);

// File: tb/decerr_sink_test.sv
module decerr_sink_test;

  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  id;
    logic [7:0]  len;
    logic [3:0]  stall;
  } vec_t;

  // stall[0]: gap before each W beat / r_ready low before each R beat
  // stall[3:1]: cycles of b_ready held low
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b1, 32'h4000_0010, 4'h3, 8'd0,  4'b0000},
    '{1'b0, 32'h5000_0020, 4'h7, 8'd0,  4'b0000},
    '{1'b1, 32'h6000_0100, 4'hA, 8'd3,  4'b0101},
    '{1'b0, 32'h7000_0200, 4'h1, 8'd4,  4'b0001},
    '{1'b1, 32'h8000_0300, 4'hF, 8'd15, 4'b0110},
    '{1'b0, 32'h9000_0400, 4'h0, 8'd15, 4'b0000},
    '{1'b1, 32'hA000_0500, 4'h5, 8'd1,  4'b0011},
    '{1'b0, 32'hB000_0600, 4'hC, 8'd2,  4'b0001}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              aw_valid = 1'b0, aw_ready;
  logic [ADDR_W-1:0] aw_addr = '0;
  logic [ID_W-1:0]   aw_id = '0;
  logic [LEN_W-1:0]  aw_len = '0;
  logic              w_valid = 1'b0, w_ready;
  logic [DATA_W-1:0] w_data = '0;
  logic [DATA_W/8-1:0] w_strb = '1;
  logic              w_last = 1'b0;
  logic              b_valid, b_ready = 1'b0;
  logic [ID_W-1:0]   b_id;
  logic [1:0]        b_resp;
  logic              ar_valid = 1'b0, ar_ready;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic [ID_W-1:0]   ar_id = '0;
  logic [LEN_W-1:0]  ar_len = '0;
  logic              r_valid, r_ready = 1'b0;
  logic [ID_W-1:0]   r_id;
  logic [DATA_W-1:0] r_data;
  logic [1:0]        r_resp;
  logic              r_last;
  logic              log_clear = 1'b0;
  logic              log_valid;
  logic [ADDR_W-1:0] log_addr;
  logic [ID_W-1:0]   log_id;
  logic              log_is_write;
  logic [CNT_W-1:0]  log_count;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  bit          exp_v = 1'b0;
  logic [31:0] exp_addr = '0;
  logic [3:0]  exp_id = '0;
  bit          exp_wr = 1'b0;
  int          exp_cnt = 0;

  always #5 clk = ~clk;

  decerr_sink #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W),
                .LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
    .log_clear(log_clear), .log_valid(log_valid), .log_addr(log_addr), .log_id(log_id),
    .log_is_write(log_is_write), .log_count(log_count)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_err(input bit wr, input logic [31:0] addr, input logic [3:0] id);
    if (!exp_v) begin
      exp_v = 1'b1; exp_wr = wr; exp_addr = addr; exp_id = id;
    end
    exp_cnt = (exp_cnt + 1 > CMAX) ? CMAX : exp_cnt + 1;
  endtask

  task automatic check_log();
    chk(log_valid == exp_v, "R6 log_valid", log_valid, exp_v);
    if (exp_v) begin
      chk(log_addr == exp_addr, "R6 log_addr", log_addr, exp_addr);
      chk(log_id == exp_id, "R6 log_id", log_id, exp_id);
      chk(log_is_write == exp_wr, "R6 log_is_write", log_is_write, exp_wr);
    end
    chk(log_count == exp_cnt, "R8 log_count", log_count, exp_cnt);
  endtask

  task automatic aw_phase(input logic [31:0] addr, input logic [3:0] id, input logic [7:0] len);
    aw_valid = 1'b1; aw_addr = addr; aw_id = id; aw_len = len;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 1'b0;
    model_err(1'b1, addr, id);
  endtask

  task automatic ar_phase(input logic [31:0] addr, input logic [3:0] id, input logic [7:0] len);
    ar_valid = 1'b1; ar_addr = addr; ar_id = id; ar_len = len;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 1'b0;
    model_err(1'b0, addr, id);
  endtask

  task automatic w_b_phase(input logic [3:0] id, input logic [7:0] len, input logic [3:0] stall);
    for (int i = 0; i <= int'(len); i++) begin
      if (stall[0]) begin
        w_valid = 1'b0;
        @(negedge clk);
      end
      w_valid = 1'b1; w_last = (i == int'(len)); w_data = 32'hD000_0000 + i;
      chk(w_ready, "R2 w_ready during burst", w_ready, 1);
      chk(!b_valid, "R2 no early b_valid", b_valid, 0);
      chk(!aw_ready, "R4 aw_ready low in data", aw_ready, 0);
      @(negedge clk);
    end
    w_valid = 1'b0; w_last = 1'b0;
    chk(!w_ready, "R2 w_ready after last", w_ready, 0);
    chk(b_valid, "R1 b_valid", b_valid, 1);
    chk(b_resp == 2'b11, "R1 b_resp", b_resp, 2'b11);
    chk(b_id == id, "R1 b_id", b_id, id);
    chk(!aw_ready, "R4 aw_ready low in resp", aw_ready, 0);
    for (int s = 0; s < int'(stall[3:1]); s++) begin
      @(negedge clk);
      chk(b_valid && b_id == id, "R5 b held", {b_valid, b_id}, {1'b1, id});
    end
    b_ready = 1'b1;
    @(negedge clk);
    b_ready = 1'b0;
    chk(!b_valid, "R1 single response", b_valid, 0);
    chk(aw_ready, "R4 aw_ready back", aw_ready, 1);
  endtask

  task automatic r_phase(input logic [3:0] id, input logic [7:0] len, input logic [3:0] stall);
    for (int i = 0; i <= int'(len); i++) begin
      if (stall[0]) begin
        r_ready = 1'b0;
        @(negedge clk);
        chk(r_valid && r_last == (i == int'(len)), "R5 r held",
            {r_valid, r_last}, {1'b1, i == int'(len)});
      end
      r_ready = 1'b1;
      chk(r_valid, "R3 r_valid", r_valid, 1);
      chk(r_last == (i == int'(len)), "R3 r_last", r_last, i == int'(len));
      chk(r_id == id, "R3 r_id", r_id, id);
      chk(r_data == '0 && r_resp == 2'b11, "R3 r_data/r_resp", {r_data, r_resp}, 2'b11);
      chk(!ar_ready, "R4 ar_ready low", ar_ready, 0);
      @(negedge clk);
    end
    r_ready = 1'b0;
    chk(!r_valid, "R3 beat count", r_valid, 0);
    chk(ar_ready, "R4 ar_ready back", ar_ready, 1);
  endtask

  task automatic do_clear();
    log_clear = 1'b1;
    @(negedge clk);
    log_clear = 1'b0;
    exp_v = 1'b0; exp_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(!b_valid && !r_valid && !w_ready, "R10 valids low", {b_valid, r_valid, w_ready}, 0);
    chk(aw_ready && ar_ready, "R10 readies high", {aw_ready, ar_ready}, 2'b11);
    chk(!log_valid && log_count == 0, "R10 log empty", {log_valid, log_count}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].wr) begin
        aw_phase(VECS[v].addr, VECS[v].id, VECS[v].len);
        check_log();
        w_b_phase(VECS[v].id, VECS[v].len, VECS[v].stall);
      end else begin
        ar_phase(VECS[v].addr, VECS[v].id, VECS[v].len);
        check_log();
        r_phase(VECS[v].id, VECS[v].len, VECS[v].stall);
      end
      check_log();
    end

    // R9 clear
    do_clear();
    check_log();

    // R7 same-cycle write and read: write recorded, count +2
    aw_valid = 1'b1; aw_addr = 32'hC000_0004; aw_id = 4'h9; aw_len = 8'd1;
    ar_valid = 1'b1; ar_addr = 32'hD000_0008; ar_id = 4'h6; ar_len = 8'd2;
    @(negedge clk);
    aw_valid = 1'b0; ar_valid = 1'b0;
    model_err(1'b1, 32'hC000_0004, 4'h9);
    model_err(1'b0, 32'hD000_0008, 4'h6);
    chk(log_is_write == 1'b1, "R7 write wins", log_is_write, 1);
    check_log();
    w_b_phase(4'h9, 8'd1, 4'b0000);
    r_phase(4'h6, 8'd2, 4'b0000);

    // R9 clear coincident with a write address handshake
    log_clear = 1'b1;
    aw_valid = 1'b1; aw_addr = 32'hE000_0000; aw_id = 4'h2; aw_len = 8'd0;
    @(negedge clk);
    log_clear = 1'b0; aw_valid = 1'b0;
    exp_v = 1'b0; exp_cnt = 0;
    chk(!log_valid && log_count == 0, "R9 clear priority", {log_valid, log_count}, 0);
    w_b_phase(4'h2, 8'd0, 4'b0000);
    ar_phase(32'hE100_0000, 4'h4, 8'd0);
    check_log();
    r_phase(4'h4, 8'd0, 4'b0000);

    // R8 saturation
    do_clear();
    for (int k = 0; k < CMAX + 1; k++) begin
      ar_phase(32'hF000_0000 + k, 4'h1, 8'd0);
      r_phase(4'h1, 8'd0, 4'b0000);
    end
    chk(log_count == CMAX, "R8 saturate", log_count, CMAX);
    aw_valid = 1'b1; aw_addr = 32'hF100_0000; aw_id = 4'h3; aw_len = 8'd0;
    ar_valid = 1'b1; ar_addr = 32'hF200_0000; ar_id = 4'h5; ar_len = 8'd0;
    @(negedge clk);
    aw_valid = 1'b0; ar_valid = 1'b0;
    model_err(1'b1, 32'hF100_0000, 4'h3);
    model_err(1'b0, 32'hF200_0000, 4'h5);
    chk(log_count == CMAX, "R8 no wrap on double", log_count, CMAX);
    check_log();
    w_b_phase(4'h3, 8'd0, 4'b0000);
    r_phase(4'h5, 8'd0, 4'b0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule